// File: doc/BRIEF.md
# Grouped-Source Interrupt Priority Controller

This block arbitrates among twenty level-sensitive on-chip interrupt sources and one encoded external request bus. It presents the most urgent pending request as a 4-bit level and a 12-bit event code. Priority is programmed in 4-bit fields packed four to a 16-bit register. Several related sources, such as the four requests of a serial port, can share a single field and still report their own event codes. A 32-bit mask has one address that sets bits and a separate address that clears them, so software never needs a read-modify-write.

The external bus carries a 4-bit value. Values 0 to 14 each select a fixed level and a fixed code, and 15 means idle. The arbiter result is registered. A one-cycle acknowledge strobe copies the code being presented into a register that software can read through the same register port.

Top module: `grp_irq_ctrl`

## Requirements
- R1: A cycle with `rst` high on a clock edge clears all priority registers, sets all 32 mask bits, and drives `irq_req`, `irq_level`, `irq_code` and the acknowledged code to 0.
- R2: Write addresses 0, 1 and 2 load `wr_data[15:0]` into priority register 0, 1 and 2. Field k lives in register k/4 at bits [4*(k%4)+3 : 4*(k%4)]. Reading the same address returns the register with bits 31:16 at 0.
- R3: Source i takes its priority from field F and reports code C. The pairs i:F/C are 0:0/0x400, 1:1/0x420, 2:2/0x440, 3:2/0x460, 4:3/0x480, 5:3/0x4A0, 6:3/0x4C0, 7:4/0x560, 8:5/0x580, 9:5/0x5A0, 10:6/0x4E0, 11:6/0x500, 12:6/0x520, 13:6/0x540, 14:8/0x620, 15:11/0x600, 16:10/0x700, 17:10/0x720, 18:10/0x740, 19:10/0x760.
- R4: Source i is pending when `src_i[i]` is 1, mask bit i is 0 and its priority is nonzero. A priority of 0 disables the source. The pending source with the highest priority wins, and among equal priorities the lowest index wins.
- R5: Writing to address 4 sets the mask bits that are 1 in `wr_data`. Writing to address 5 clears the mask bits that are 1 in `wr_data`. Other mask bits keep their value. Addresses 4 and 5 both read back the mask. Bits 20 to 31 are stored but gate nothing.
- R6: An `ext_req` value n below 15 is a request with level 15-n and code 0x200+0x20*n. The value 15 is no request. The external request is never masked, and it wins a tie against an internal source of equal level.
- R7: The outputs are registered and reflect the inputs and register contents one clock edge earlier. With nothing pending, `irq_req`, `irq_level` and `irq_code` are all 0.
- R8: A clock edge with `ack` high copies the `irq_code` value presented before that edge into the acknowledged-code register, read at address 6 with bits 31:12 at 0.
- R9: `rd_data` is registered and returns the contents at `rd_addr` one edge later. Addresses 3 and 7 read 0. Writes to addresses 3, 6 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data |
| src_i | input | 20 | Level interrupt sources |
| ext_req | input | 4 | Encoded external request, 15 = idle |
| ack | input | 1 | Acknowledge strobe |
| irq_req | output | 1 | A request is being presented |
| irq_level | output | 4 | Level of the presented request |
| irq_code | output | 12 | Event code of the presented request |

## Verification
The assertions assume the block leaves reset with `rst` held through at least one edge. They also assume that sources, mask and priorities are sampled only on clock edges, so a one-edge lag between a write and its effect on arbitration is the expected behaviour. The stimulus respects this. Inputs change only on falling edges. Register writes are one-cycle pulses that finish before the sources under test are applied. The outputs are compared only after the edge that registers the arbitration result. The random phase draws priorities, mask operations, source vectors and external codes from a fixed seed. The directed cases cover ties, disabled sources, group members and the ends of the external code range.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int SRC_N   = 20;
  localparam int FIELD_W = 4;
  localparam int CODE_W  = 12;
  localparam int PREG_W  = 16;
  localparam int PREG_N  = 3;
  localparam int FIELD_N = PREG_N * (PREG_W / FIELD_W);
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 32;
  localparam int MASK_W  = 32;

  localparam logic [ADDR_W-1:0] ADDR_MSET = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_MCLR = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_ACK  = 3'd6;

  // priority field that governs each source
  function automatic int src_field(input int i);
    case (i)
      0: return 0;   1: return 1;   2, 3: return 2;
      4, 5, 6: return 3;            7: return 4;
      8, 9: return 5;
      10, 11, 12, 13: return 6;
      14: return 8;  15: return 11;
      default: return 10;
    endcase
  endfunction

  // event code reported by each source
  function automatic logic [CODE_W-1:0] src_code(input int i);
    case (i)
      0:  return 12'h400;  1:  return 12'h420;
      2:  return 12'h440;  3:  return 12'h460;
      4:  return 12'h480;  5:  return 12'h4A0;
      6:  return 12'h4C0;  7:  return 12'h560;
      8:  return 12'h580;  9:  return 12'h5A0;
      10: return 12'h4E0;  11: return 12'h500;
      12: return 12'h520;  13: return 12'h540;
      14: return 12'h620;  15: return 12'h600;
      16: return 12'h700;  17: return 12'h720;
      18: return 12'h740;  default: return 12'h760;
    endcase
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctrl_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  input  logic                      ack,
  input  logic [CODE_W-1:0]         cur_code,
  output logic [PREG_N*PREG_W-1:0]  fields,
  output logic [MASK_W-1:0]         mask_q
);
  logic [PREG_W-1:0] preg_q [PREG_N];
  logic [CODE_W-1:0] ack_q;

  for (genvar r = 0; r < PREG_N; r++) begin : g_preg
    always_ff @(posedge clk) begin
      if (rst) preg_q[r] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(r)) preg_q[r] <= wr_data[PREG_W-1:0];
    end
    assign fields[r*PREG_W +: PREG_W] = preg_q[r];

    // R2
    prio_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == ADDR_W'(r)) |=> preg_q[r] == $past(wr_data[PREG_W-1:0]));
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else if (wr_en && wr_addr == ADDR_MSET) mask_q <= mask_q | wr_data;
    else if (wr_en && wr_addr == ADDR_MCLR) mask_q <= mask_q & ~wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) ack_q <= '0;
    else if (ack) ack_q <= cur_code;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      rd_data <= '0;
      if (int'(rd_addr) < PREG_N) rd_data <= DATA_W'(preg_q[rd_addr]);
      else if (rd_addr == ADDR_MSET || rd_addr == ADDR_MCLR) rd_data <= mask_q;
      else if (rd_addr == ADDR_ACK) rd_data <= DATA_W'(ack_q);
    end
  end

  // R5
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_MSET) |=> (mask_q & $past(wr_data)) == $past(wr_data));
  // R5
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_MCLR) |=> (mask_q & $past(wr_data)) == '0);
  // R8
  ack_latch_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> ack_q == $past(cur_code));
  // R1
  rst_mask_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '1 && ack_q == '0));
endmodule

// File: rtl/irq_ext_dec.sv
module irq_ext_dec
  import irq_ctrl_pkg::*;
(
  input  logic [3:0]         ext_req,
  output logic [FIELD_W-1:0] ext_lvl,
  output logic [CODE_W-1:0]  ext_code
);
  always_comb begin
    if (ext_req == 4'hF) begin
      ext_lvl  = '0;
      ext_code = '0;
    end else begin
      ext_lvl  = FIELD_W'(4'hF - ext_req);
      ext_code = CODE_W'(12'h200 + ({8'h00, ext_req} << 5));
    end
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_ctrl_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [SRC_N-1:0]          src,
  input  logic [SRC_N-1:0]          mask,
  input  logic [PREG_N*PREG_W-1:0]  fields,
  input  logic [FIELD_W-1:0]        ext_lvl,
  input  logic [CODE_W-1:0]         ext_code,
  output logic                      irq_req,
  output logic [FIELD_W-1:0]        irq_level,
  output logic [CODE_W-1:0]         irq_code
);
  logic [FIELD_W-1:0] pri  [SRC_N];
  logic [SRC_N-1:0]   elig;
  logic [FIELD_W-1:0] best_lvl;
  logic [CODE_W-1:0]  best_code;

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    localparam int FIdx = src_field(i);
    assign pri[i]  = fields[FIdx*FIELD_W +: FIELD_W];
    assign elig[i] = src[i] & ~mask[i] & (pri[i] != '0);

    // R4
    lvl_floor_chk: assert property (@(posedge clk) disable iff (rst)
      elig[i] |=> irq_level >= $past(pri[i]));
  end

  // external request seeds the search so it keeps ties; strict compare keeps lowest index
  always_comb begin
    best_lvl  = ext_lvl;
    best_code = ext_code;
    for (int i = 0; i < SRC_N; i++) begin
      if (elig[i] && pri[i] > best_lvl) begin
        best_lvl  = pri[i];
        best_code = src_code(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      irq_level <= '0;
      irq_code  <= '0;
    end else begin
      irq_req   <= best_lvl != '0;
      irq_level <= best_lvl;
      irq_code  <= (best_lvl != '0) ? best_code : '0;
    end
  end

  // R7
  req_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_level == '0 && irq_code == '0));
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [2:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic [19:0]       src_i,
  input  logic [3:0]        ext_req,
  input  logic              ack,
  output logic              irq_req,
  output logic [3:0]        irq_level,
  output logic [11:0]       irq_code
);
  logic [PREG_N*PREG_W-1:0] fields;
  logic [MASK_W-1:0]        mask_q;
  logic [FIELD_W-1:0]       ext_lvl;
  logic [CODE_W-1:0]        ext_code;

  irq_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ack(ack), .cur_code(irq_code),
    .fields(fields), .mask_q(mask_q)
  );

  irq_ext_dec u_ext (.ext_req(ext_req), .ext_lvl(ext_lvl), .ext_code(ext_code));

  irq_arb u_arb (
    .clk(clk), .rst(rst), .src(src_i), .mask(mask_q[SRC_N-1:0]), .fields(fields),
    .ext_lvl(ext_lvl), .ext_code(ext_code),
    .irq_req(irq_req), .irq_level(irq_level), .irq_code(irq_code)
  );

  // R7
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (src_i == '0 && ext_req == 4'hF) |=> !irq_req);
  // R6
  ext_top_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_req == 4'h0) |=> (irq_level == 4'hF && irq_code == 12'h200));
endmodule

// File: tb/tb_grp_irq_ctrl.sv
module tb_grp_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, wr_en = 0, ack = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [19:0] src_i = 0;
  logic [3:0] ext_req = 4'hF, irq_level;
  logic [11:0] irq_code;
  logic irq_req;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [15:0] m_preg [3];
  logic [31:0] m_mask;
  logic [11:0] m_ack;
  logic [3:0]  e_lvl;
  logic [11:0] e_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  grp_irq_ctrl dut (.*);

  function automatic int b_field(int i);
    int t [20] = '{0,1,2,2,3,3,3,4,5,5,6,6,6,6,8,11,10,10,10,10};
    return t[i];
  endfunction
  function automatic logic [11:0] b_code(int i);
    logic [11:0] t [20] = '{12'h400,12'h420,12'h440,12'h460,12'h480,12'h4A0,12'h4C0,
      12'h560,12'h580,12'h5A0,12'h4E0,12'h500,12'h520,12'h540,12'h620,12'h600,
      12'h700,12'h720,12'h740,12'h760};
    return t[i];
  endfunction

  task automatic model_eval(input logic [19:0] s, input logic [3:0] e);
    e_lvl = 0; e_code = 0;
    if (e != 4'hF) begin e_lvl = 4'hF - e; e_code = 12'h200 + 12'(e) * 12'h20; end
    for (int i = 0; i < 20; i++) begin
      int f = b_field(i);
      logic [3:0] p = m_preg[f/4][4*(f%4) +: 4];
      if (s[i] && !m_mask[i] && p != 0 && p > e_lvl) begin e_lvl = p; e_code = b_code(i); end
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
    if (a < 3) m_preg[a] = d[15:0];
    else if (a == 3'd4) m_mask = m_mask | d;
    else if (a == 3'd5) m_mask = m_mask & ~d;
  endtask

  task automatic apply(input string tag, input logic [19:0] s, input logic [3:0] e);
    @(negedge clk); src_i = s; ext_req = e;
    @(negedge clk);
    model_eval(s, e);
    chk({tag, " level"}, 32'(irq_level), 32'(e_lvl));
    chk({tag, " code"}, 32'(irq_code), 32'(e_code));
    chk({tag, " req"}, 32'(irq_req), 32'(e_lvl != 0));
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk); rd_addr = a;
    @(negedge clk); chk(tag, rd_data, exp);
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1; m_ack = e_code;
    @(negedge clk); ack = 0;
  endtask

  initial begin
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    n_bad++;
    $display("FAIL watchdog actual=%0d expected<100000", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_preg[0] = 0; m_preg[1] = 0; m_preg[2] = 0; m_mask = '1; m_ack = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 req", 32'(irq_req), 0);
    chk("R1 level", 32'(irq_level), 0);
    chk("R1 code", 32'(irq_code), 0);
    rd_chk("R1 mask", 3'd4, 32'hFFFF_FFFF);
    rd_chk("R1 prio", 3'd1, 0);
    rd_chk("R1 ack", 3'd6, 0);
    apply("R4 all masked", 20'hFFFFF, 4'hF);
    // R2 field placement and readback
    wr(3'd0, 32'hABCD_0055);
    rd_chk("R2 readback", 3'd0, 32'h0000_0055);
    // R5 mask clear then set
    wr(3'd5, 32'h000F_FFFF);
    rd_chk("R5 clear", 3'd5, 32'hFFF0_0000);
    // R4 tie: fields 0 and 1 both 5, lowest index wins
    apply("R4 tie", 20'h00003, 4'hF);
    // R4 priority zero disables (field 2 is 0)
    apply("R4 prio0", 20'h00004, 4'hF);
    // R3 group: field 6 = 7, members keep own codes
    wr(3'd1, 32'h0000_0700);
    apply("R3 group tx", 20'h01000, 4'hF);
    apply("R3 group rx", 20'h01800, 4'hF);
    wr(3'd4, 32'h0000_0800);
    apply("R5 masked member", 20'h01800, 4'hF);
    // R6 external ends and tie
    apply("R6 ext0", 20'h00000, 4'h0);
    apply("R6 ext14", 20'h00000, 4'hE);
    wr(3'd0, 32'h0000_0001);
    apply("R6 ext tie", 20'h00001, 4'hE);
    apply("R6 ext idle", 20'h00001, 4'hF);
    // R8 ack
    apply("R8 setup", 20'h01000, 4'hF);
    do_ack();
    rd_chk("R8 ack read", 3'd6, 32'(m_ack));
    // R9 ignored writes and empty reads
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    wr(3'd6, 32'h0000_0123);
    rd_chk("R9 addr3", 3'd3, 0);
    rd_chk("R9 addr7", 3'd7, 0);
    rd_chk("R9 ack kept", 3'd6, 32'(m_ack));
    rd_chk("R9 prio kept", 3'd0, 32'(m_preg[0]));
    // R7 idle
    apply("R7 idle", 20'h00000, 4'hF);
    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 4);
      if (op < 2) wr(3'($urandom_range(0, 2)), $urandom);
      else if (op == 2) wr(3'd4, $urandom & $urandom);
      else if (op == 3) wr(3'd5, $urandom);
      apply("R4 random", 20'($urandom), ($urandom_range(0, 3) == 0) ? 4'hF : 4'($urandom));
      if (it % 16 == 0) begin
        do_ack();
        rd_chk("R8 random ack", 3'd6, 32'(m_ack));
        rd_chk("R5 random mask", 3'd4, m_mask);
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule